// File: doc/BRIEF.md
# Multichannel DAC Scan FIFO Controller

This block sits between a host register port and a bank of DAC channels. The host writes 16-bit sample words into a deep FIFO. A scan trigger then sends one word to each enabled channel, in ascending channel order, as a stream of channel-index and sample pairs. A single 16-bit control word chooses the scan trigger from eight codes, picks one of six FIFO fill conditions for a level interrupt, enables the FIFO, and turns on wraparound playback. The same word reads back a coded coarse fill level and a busy flag. The polarity and reference-select fields are only stored and read back, because they act on the analog side.

The host port is a single-cycle register bus. The byte offset is decoded on address bits 2:1, and bit 0 is ignored. Offset 0x00 is the sample port: a write pushes a word, and a read issues a software trigger and returns zero. Offset 0x02 is the control/status word. Offset 0x04 holds the wraparound length and offset 0x06 holds the channel-enable mask. Both are write-only and read as zero. The bus has no back-pressure: a write that finds the FIFO full is dropped.

The sample output is a valid/ready stream. While a scan is active, `smp_valid` stays high and `smp_chan`/`smp_data` hold steady until `smp_ready` is seen. A word leaves the FIFO only on a cycle where both are high. The sink may stall for as long as it likes, and while it stalls the scan stays busy.

Top module: `dac_scan_fifo_ctrl`

## Requirements
- R1: After reset, the control word reads 16'h1000 (every stored field is zero, the fill code is "empty", busy is low), and `smp_valid`, `fifo_irq` and `underrun` are all low.
- R2: Control bits 2:0 (trigger select), 3 (polarity), 5:4 (reference select), 7 (wraparound) and 11:8 (FIFO enable in bit 8, interrupt level in 11:9) are stored and read back unchanged. Bit 6 always reads 0.
- R3: Control bits 14:12 read the fill code: 3'b001 when empty, 3'b000 for 1 to DEPTH/2 words, 3'b100 for DEPTH/2+1 to DEPTH-1 words, and 3'b110 when full.
- R4: With trigger select 1, a bus read of offset 0x00 starts a scan. With any other select, such a read starts nothing.
- R5: A scan emits one word per enabled channel (mask bit n = channel n). Channels come out in ascending order, and words come out in the order they were written. The mask is captured when the trigger is accepted.
- R6: While `smp_valid` is high and `smp_ready` is low, `smp_valid`, `smp_chan` and `smp_data` hold. A word is consumed only on a handshake.
- R7: Control bit 15 reads 1 from the cycle after a trigger is accepted until the handshake of the scan's last word.
- R8: A trigger is ignored, and sets the sticky `underrun` flag, if it arrives while a scan is busy or while the FIFO holds fewer words than there are enabled channels. A trigger with an all-zero mask is ignored silently.
- R9: The external trigger passes through two synchronizer flops. Select 2 fires on its rising edge and select 3 on its falling edge. An edge of the other polarity does nothing.
- R10: Selects 4, 5 and 6 fire on the rising edge of `tmr_out[0]`, `tmr_out[1]` and `tmr_out[2]`. Selects 0 and 7 never fire.
- R11: `fifo_irq` is high while FIFO enable is set and the condition chosen by bits 11:9 holds: 0 empty, 1 not empty, 2 at most DEPTH/2 words, 3 more than DEPTH/2 words, 4 not full, 5 full. Codes 6 and 7 never assert.
- R12: With FIFO enable clear, sample writes are dropped, triggers are ignored without raising `underrun`, and `fifo_irq` stays low. A write to a full FIFO is dropped.
- R13: With bit 7 set, consumed words stay in the FIFO and the read position wraps back to the first word after the wraparound length. A length of 0 means DEPTH.
- R14: Writing control bit 12 empties the FIFO, aborts any scan and clears `underrun`, and the other written fields are stored. Writing bit 13 does the same and also clears the control fields, the channel mask and the wraparound length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Byte offset (bits 2:1 decoded) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| ext_trig | input | 1 | Asynchronous external trigger |
| tmr_out | input | 3 | Timer outputs used as scan triggers |
| smp_valid | output | 1 | Sample word available |
| smp_ready | input | 1 | Sink accepts the sample |
| smp_chan | output | CIW | Channel index of the sample |
| smp_data | output | 16 | Sample word |
| fifo_irq | output | 1 | Level FIFO interrupt |
| underrun | output | 1 | Sticky flag for ignored triggers |

## Verification
The bench builds the block with DEPTH = 16 and NCH = 8. With that FIFO size, every fill-code band, the half-full and full interrupt conditions, a dropped write into a full FIFO, and a full-length wraparound (length 0) are reached within a few dozen writes. With eight channels, a sparse mask (0, 2, 5, 7) and a full mask can both be exercised, and an all-zero mask can be exercised after a global reset.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

  typedef enum logic [2:0] {
    TRIG_OFF      = 3'd0,
    TRIG_SOFT     = 3'd1,
    TRIG_EXT_RISE = 3'd2,
    TRIG_EXT_FALL = 3'd3,
    TRIG_TMR0     = 3'd4,
    TRIG_TMR1     = 3'd5,
    TRIG_TMR2     = 3'd6,
    TRIG_RSVD     = 3'd7
  } trig_sel_e;

  typedef enum logic [2:0] {
    IRQ_EMPTY     = 3'd0,
    IRQ_NOT_EMPTY = 3'd1,
    IRQ_NOT_HALF  = 3'd2,
    IRQ_HALF      = 3'd3,
    IRQ_NOT_FULL  = 3'd4,
    IRQ_FULL      = 3'd5,
    IRQ_RSVD6     = 3'd6,
    IRQ_RSVD7     = 3'd7
  } irq_lvl_e;

  localparam logic [2:0] FILL_EMPTY = 3'b001;
  localparam logic [2:0] FILL_LOW   = 3'b000;
  localparam logic [2:0] FILL_HIGH  = 3'b100;
  localparam logic [2:0] FILL_FULL  = 3'b110;

  // register select = byte offset bits 2:1
  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_WRAP = 2'd2;
  localparam logic [1:0] REG_CHEN = 2'd3;

  localparam int CTRL_WRAP_BIT = 7;
  localparam int CTRL_FEN_BIT  = 8;
  localparam int CTRL_FRST_BIT = 12;
  localparam int CTRL_GRST_BIT = 13;
  localparam logic [15:0] CTRL_KEEP_MASK = 16'h0FBF;

  localparam int NUM_TMR = 3;

endpackage

// File: rtl/dsf_fifo.sv
module dsf_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  input  logic          wrap_en,
  input  logic [AW-1:0] wrap_size,
  output logic [CW-1:0] count,
  output logic [DW-1:0] head
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW-1:0] wrap_last;
  logic          push_ok, pop_ok;

  // size 0 underflows to all ones, i.e. DEPTH-1 (DEPTH is a power of two)
  assign wrap_last = wrap_size - 1'b1;
  assign push_ok   = push && (count != FULL_CNT) && !clr;
  assign pop_ok    = pop && (count != '0) && !clr;
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok) begin
        if (wrap_en) rd_ptr <= (rd_ptr == wrap_last) ? '0 : rd_ptr + 1'b1;
        else         rd_ptr <= rd_ptr + 1'b1;
      end
      count <= count + CW'(push_ok) - CW'(pop_ok && !wrap_en);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT); // R12
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !clr |-> count != '0); // R5
  AST_WRAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    pop && wrap_en && !push && !clr |=> count == $past(count)); // R13
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0); // R14

endmodule

// File: rtl/dsf_trig_sel.sv
module dsf_trig_sel
  import dsf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  trig_sel_e          sel,
  input  logic               sw_pulse,
  input  logic               ext_in,
  input  logic [NUM_TMR-1:0] tmr_in,
  output logic               trig
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev;
  logic                   ext_rise, ext_fall;
  logic [NUM_TMR-1:0]     tmr_prev;
  logic [NUM_TMR-1:0]     tmr_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      ext_prev <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], ext_in};
      ext_prev <= sync_q[SYNC_STAGES-1];
    end
  end

  assign ext_rise =  sync_q[SYNC_STAGES-1] && !ext_prev;
  assign ext_fall = !sync_q[SYNC_STAGES-1] &&  ext_prev;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tmr_prev[g] <= 1'b0;
      else        tmr_prev[g] <= tmr_in[g];
    end
    assign tmr_rise[g] = tmr_in[g] && !tmr_prev[g];
  end

  always_comb begin
    case (sel)
      TRIG_SOFT:     trig = sw_pulse;
      TRIG_EXT_RISE: trig = ext_rise;
      TRIG_EXT_FALL: trig = ext_fall;
      TRIG_TMR0:     trig = tmr_rise[0];
      TRIG_TMR1:     trig = tmr_rise[1];
      TRIG_TMR2:     trig = tmr_rise[2];
      default:       trig = 1'b0;
    endcase
  end

  AST_EXT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |-> $past(ext_in, 2)); // R9

endmodule

// File: rtl/dsf_scan_seq.sv
module dsf_scan_seq #(
  parameter int NCH  = 16,
  parameter int CW   = 13,
  localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           abort,
  input  logic           trig,
  input  logic           fifo_en,
  input  logic [NCH-1:0] chan_mask,
  input  logic [CW-1:0]  fifo_count,
  output logic           smp_valid,
  input  logic           smp_ready,
  output logic [CIW-1:0] smp_chan,
  output logic           pop,
  output logic           busy,
  output logic           reject
);

  logic [NCH-1:0] pending_q;
  logic [CW-1:0]  nreq;
  logic           short_fifo, accept;

  always_comb begin
    nreq = '0;
    for (int i = 0; i < NCH; i++) nreq = nreq + CW'(chan_mask[i]);
  end

  always_comb begin
    smp_chan = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pending_q[i]) smp_chan = CIW'(i);
    end
  end

  assign busy       = |pending_q;
  assign smp_valid  = busy;
  assign pop        = smp_valid && smp_ready;
  assign short_fifo = fifo_count < nreq;
  assign accept     = trig && fifo_en && !busy && !short_fifo && (|chan_mask);
  assign reject     = trig && fifo_en && (busy || short_fifo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pending_q <= '0;
    else if (abort)  pending_q <= '0;
    else if (accept) pending_q <= chan_mask;
    else if (pop)    pending_q <= pending_q & ~(NCH'(1) << smp_chan);
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready && !abort |=> smp_valid && $stable(smp_chan)); // R6
  AST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_ready && !abort |=> !smp_valid || (smp_chan > $past(smp_chan))); // R5
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig) && $past(fifo_en)); // R7

endmodule

// File: rtl/dac_scan_fifo_ctrl.sv
module dac_scan_fifo_ctrl
  import dsf_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int NCH   = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int CIW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_valid,
  input  logic           bus_write,
  input  logic [2:0]     bus_addr,
  input  logic [15:0]    bus_wdata,
  output logic [15:0]    bus_rdata,
  input  logic           ext_trig,
  input  logic [2:0]     tmr_out,
  output logic           smp_valid,
  input  logic           smp_ready,
  output logic [CIW-1:0] smp_chan,
  output logic [15:0]    smp_data,
  output logic           fifo_irq,
  output logic           underrun
);

  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [15:0]    ctrl_q;
  logic [NCH-1:0] chen_q;
  logic [AW-1:0]  wrap_q;
  logic           underrun_q;

  logic [1:0]     reg_sel;
  logic           wr_cyc, rd_cyc, ctrl_wr, glb_rst, fifo_clr;
  logic           fen, wrap_en, push, sw_pulse;
  logic           trig, pop, busy, reject;
  logic [CW-1:0]  count;
  logic [2:0]     fill_code;
  logic           irq_cond;
  logic           unused_bits;

  assign reg_sel  = bus_addr[2:1];
  assign wr_cyc   = bus_valid && bus_write;
  assign rd_cyc   = bus_valid && !bus_write;
  assign ctrl_wr  = wr_cyc && (reg_sel == REG_CTRL);
  assign glb_rst  = ctrl_wr && bus_wdata[CTRL_GRST_BIT];
  assign fifo_clr = ctrl_wr && (bus_wdata[CTRL_FRST_BIT] || bus_wdata[CTRL_GRST_BIT]);
  assign fen      = ctrl_q[CTRL_FEN_BIT];
  assign wrap_en  = ctrl_q[CTRL_WRAP_BIT];
  assign push     = wr_cyc && (reg_sel == REG_DATA) && fen;
  assign sw_pulse = rd_cyc && (reg_sel == REG_DATA);

  assign unused_bits = ^{bus_addr[0], bus_wdata};

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      chen_q     <= '0;
      wrap_q     <= '0;
      underrun_q <= 1'b0;
    end else begin
      if (glb_rst) begin
        ctrl_q <= '0;
        chen_q <= '0;
        wrap_q <= '0;
      end else begin
        if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_KEEP_MASK;
        if (wr_cyc && reg_sel == REG_CHEN) chen_q <= bus_wdata[NCH-1:0];
        if (wr_cyc && reg_sel == REG_WRAP) wrap_q <= bus_wdata[AW-1:0];
      end
      if (fifo_clr)    underrun_q <= 1'b0;
      else if (reject) underrun_q <= 1'b1;
    end
  end

  dsf_fifo #(.DW(16), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fifo_clr),
    .push      (push),
    .wdata     (bus_wdata),
    .pop       (pop),
    .wrap_en   (wrap_en),
    .wrap_size (wrap_q),
    .count     (count),
    .head      (smp_data)
  );

  dsf_trig_sel u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (trig_sel_e'(ctrl_q[2:0])),
    .sw_pulse (sw_pulse),
    .ext_in   (ext_trig),
    .tmr_in   (tmr_out),
    .trig     (trig)
  );

  dsf_scan_seq #(.NCH(NCH), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (fifo_clr),
    .trig       (trig),
    .fifo_en    (fen),
    .chan_mask  (chen_q),
    .fifo_count (count),
    .smp_valid  (smp_valid),
    .smp_ready  (smp_ready),
    .smp_chan   (smp_chan),
    .pop        (pop),
    .busy       (busy),
    .reject     (reject)
  );

  // coarse fill code
  always_comb begin
    if (count == '0)           fill_code = FILL_EMPTY;
    else if (count <= HALF_CNT) fill_code = FILL_LOW;
    else if (count != FULL_CNT) fill_code = FILL_HIGH;
    else                        fill_code = FILL_FULL;
  end

  // interrupt level select
  always_comb begin
    case (irq_lvl_e'(ctrl_q[11:9]))
      IRQ_EMPTY:     irq_cond = (count == '0);
      IRQ_NOT_EMPTY: irq_cond = (count != '0);
      IRQ_NOT_HALF:  irq_cond = (count <= HALF_CNT);
      IRQ_HALF:      irq_cond = (count > HALF_CNT);
      IRQ_NOT_FULL:  irq_cond = (count != FULL_CNT);
      IRQ_FULL:      irq_cond = (count == FULL_CNT);
      default:       irq_cond = 1'b0;
    endcase
  end

  assign fifo_irq = fen && irq_cond;
  assign underrun = underrun_q;

  always_comb begin
    case (reg_sel)
      REG_CTRL: bus_rdata = {busy, fill_code, ctrl_q[11:0]};
      default:  bus_rdata = '0;
    endcase
  end

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_q && !fifo_clr |=> underrun_q); // R8
  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    reject && !fifo_clr |=> underrun_q); // R8
  AST_DROP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !fen && !fifo_clr |=> count == $past(count) || smp_valid); // R12

endmodule

// File: tb/dac_scan_fifo_ctrl_tb_top.sv
module dac_scan_fifo_ctrl_tb_top;

  localparam int DEPTH = 16;
  localparam int NCH   = 8;
  localparam int CIW   = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0]     bus_addr = '0;
  logic [15:0]    bus_wdata = '0;
  logic [15:0]    bus_rdata;
  logic           ext_trig = 1'b0;
  logic [2:0]     tmr_out = '0;
  logic           smp_valid, smp_ready = 1'b0;
  logic [CIW-1:0] smp_chan;
  logic [15:0]    smp_data;
  logic           fifo_irq, underrun;

  int n_checks = 0;
  int n_err    = 0;
  logic [CIW-1:0] exp_ch [32];
  logic [15:0]    exp_d  [32];

  always #4ns clk = ~clk;

  dac_scan_fifo_ctrl #(.DEPTH(DEPTH), .NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_trig(ext_trig), .tmr_out(tmr_out), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_chan(smp_chan), .smp_data(smp_data),
    .fifo_irq(fifo_irq), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1ns d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic sw_trig();
    logic [15:0] d;
    bus_rd(3'h0, d);
  endtask

  task automatic chk_ctrl(input logic [15:0] exp, input string req);
    logic [15:0] d;
    bus_rd(3'h2, d);
    chk(d == exp, req, "ctrl", d, exp);
  endtask

  task automatic push_n(input logic [15:0] base, input int n);
    for (int k = 0; k < n; k++) bus_wr(3'h0, base + 16'(k));
  endtask

  task automatic plan_scan(input logic [7:0] mask, input logic [15:0] base, input int n);
    int k = 0;
    while (k < n) begin
      for (int c = 0; c < NCH; c++) begin
        if (mask[c] && k < n) begin
          exp_ch[k] = CIW'(c); exp_d[k] = base + 16'(k); k++;
        end
      end
    end
  endtask

  task automatic take(input int n, input string req);
    int got = 0;
    int waitc = 0;
    smp_ready = 1'b1;
    while (got < n && waitc < 40) begin
      if (smp_valid) begin
        chk(smp_chan == exp_ch[got] && smp_data == exp_d[got], req, "sample",
            {smp_chan, smp_data}, {exp_ch[got], exp_d[got]});
        got++;
      end
      @(negedge clk);
      waitc++;
    end
    smp_ready = 1'b0;
    chk(got == n, req, "sample count", got, n);
  endtask

  task automatic expect_idle(input int cyc, input string req);
    bit seen = 1'b0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (smp_valid) seen = 1'b1;
    end
    chk(!seen, req, "no scan", seen, 0);
  endtask

  task automatic t_reset();
    chk_ctrl(16'h1000, "R1");
    chk(!smp_valid && !fifo_irq && !underrun, "R1", "outputs", {smp_valid, fifo_irq, underrun}, 0);
  endtask

  task automatic t_ctrl_fields();
    bus_wr(3'h2, 16'h0FFF);
    chk_ctrl(16'h1FBF, "R2");
    bus_wr(3'h2, 16'h2000);
    chk_ctrl(16'h1000, "R14");
  endtask

  task automatic t_fill_and_irq();
    bus_wr(3'h2, 16'h0101);
    push_n(16'hA000, 1);
    chk_ctrl(16'h0101, "R3");
    push_n(16'hA001, 7);
    chk_ctrl(16'h0101, "R3");
    push_n(16'hA008, 1);
    chk_ctrl(16'h4101, "R3");
    push_n(16'hA009, 7);
    chk_ctrl(16'h6101, "R3");
    bus_wr(3'h0, 16'hDEAD);
    chk_ctrl(16'h6101, "R12");
    bus_wr(3'h2, 16'h0B01);
    chk(fifo_irq == 1'b1, "R11", "irq full", fifo_irq, 1);
    bus_wr(3'h2, 16'h0901);
    chk(fifo_irq == 1'b0, "R11", "irq not full", fifo_irq, 0);
    bus_wr(3'h2, 16'h0701);
    chk(fifo_irq == 1'b1, "R11", "irq half", fifo_irq, 1);
    bus_wr(3'h2, 16'h0101);
  endtask

  task automatic t_soft_scan();
    bus_wr(3'h6, 16'h00FF);
    sw_trig();
    chk_ctrl(16'hE101, "R7");
    repeat (3) @(negedge clk);
    chk(smp_valid && smp_chan == 0 && smp_data == 16'hA000, "R6", "held",
        {smp_valid, smp_chan, smp_data}, {1'b1, 3'd0, 16'hA000});
    plan_scan(8'hFF, 16'hA000, 8);
    take(8, "R5");
    chk_ctrl(16'h0101, "R7");
    sw_trig();
    plan_scan(8'hFF, 16'hA008, 8);
    take(8, "R12");
    chk_ctrl(16'h1101, "R3");
    chk(fifo_irq == 1'b1, "R11", "irq empty", fifo_irq, 1);
    bus_wr(3'h2, 16'h0301);
    chk(fifo_irq == 1'b0, "R11", "irq not empty", fifo_irq, 0);
    bus_wr(3'h2, 16'h0501);
    chk(fifo_irq == 1'b1, "R11", "irq not half", fifo_irq, 1);
    bus_wr(3'h2, 16'h0101);
  endtask

  task automatic t_underrun();
    bus_wr(3'h6, 16'h00A5);
    push_n(16'hB000, 3);
    sw_trig();
    chk(underrun == 1'b1, "R8", "short fifo", underrun, 1);
    expect_idle(4, "R8");
    push_n(16'hB003, 1);
    sw_trig();
    plan_scan(8'hA5, 16'hB000, 4);
    take(4, "R5");
    chk(underrun == 1'b1, "R8", "sticky", underrun, 1);
    bus_wr(3'h2, 16'h1101);
    chk(underrun == 1'b0, "R14", "fifo reset clears", underrun, 0);
    chk_ctrl(16'h1101, "R14");
    push_n(16'hC000, 4);
    sw_trig();
    sw_trig();
    chk(underrun == 1'b1, "R8", "busy trigger", underrun, 1);
    plan_scan(8'hA5, 16'hC000, 4);
    take(4, "R8");
    expect_idle(4, "R8");
    bus_wr(3'h2, 16'h1101);
  endtask

  task automatic t_external();
    bus_wr(3'h2, 16'h0102);
    push_n(16'hD000, 4);
    sw_trig();
    expect_idle(4, "R4");
    @(negedge clk) ext_trig = 1'b1;
    plan_scan(8'hA5, 16'hD000, 4);
    take(4, "R9");
    push_n(16'hE000, 4);
    @(negedge clk) ext_trig = 1'b0;
    expect_idle(6, "R9");
    bus_wr(3'h2, 16'h0103);
    @(negedge clk) ext_trig = 1'b1;
    expect_idle(6, "R9");
    @(negedge clk) ext_trig = 1'b0;
    plan_scan(8'hA5, 16'hE000, 4);
    take(4, "R9");
  endtask

  task automatic t_timers();
    bus_wr(3'h2, 16'h0105);
    push_n(16'hF000, 4);
    @(negedge clk) tmr_out[0] = 1'b1;
    expect_idle(5, "R10");
    @(negedge clk) tmr_out[1] = 1'b1;
    plan_scan(8'hA5, 16'hF000, 4);
    take(4, "R10");
    bus_wr(3'h2, 16'h0100);
    push_n(16'hF100, 4);
    @(negedge clk) tmr_out = 3'b000;
    @(negedge clk) tmr_out = 3'b111;
    sw_trig();
    expect_idle(5, "R10");
    tmr_out = 3'b000;
  endtask

  task automatic t_disabled();
    bus_wr(3'h2, 16'h1001);
    push_n(16'h7777, 1);
    chk_ctrl(16'h1001, "R12");
    chk(fifo_irq == 1'b0, "R12", "irq gated", fifo_irq, 0);
    sw_trig();
    chk(underrun == 1'b0, "R12", "no underrun", underrun, 0);
    expect_idle(4, "R12");
  endtask

  task automatic t_wrap();
    bus_wr(3'h4, 16'd3);
    bus_wr(3'h2, 16'h1181);
    bus_wr(3'h6, 16'h0001);
    bus_wr(3'h0, 16'h1111);
    bus_wr(3'h0, 16'h2222);
    bus_wr(3'h0, 16'h3333);
    for (int k = 0; k < 4; k++) begin
      sw_trig();
      exp_ch[0] = '0;
      exp_d[0]  = (k % 3 == 0) ? 16'h1111 : (k % 3 == 1) ? 16'h2222 : 16'h3333;
      take(1, "R13");
    end
    chk_ctrl(16'h0181, "R13");
    bus_wr(3'h4, 16'd0);
    bus_wr(3'h2, 16'h1181);
    bus_wr(3'h6, 16'h00FF);
    push_n(16'h5000, 16);
    sw_trig();
    plan_scan(8'hFF, 16'h5000, 8);
    take(8, "R13");
    sw_trig();
    plan_scan(8'hFF, 16'h5008, 8);
    take(8, "R13");
    sw_trig();
    plan_scan(8'hFF, 16'h5000, 8);
    take(8, "R13");
    chk_ctrl(16'h6181, "R13");
  endtask

  task automatic t_global();
    bus_wr(3'h2, 16'h2000);
    chk_ctrl(16'h1000, "R14");
    bus_wr(3'h2, 16'h0101);
    push_n(16'h9000, 1);
    sw_trig();
    expect_idle(4, "R14");
    chk(underrun == 1'b0, "R14", "mask cleared", underrun, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_fields();
    t_fill_and_irq();
    t_soft_scan();
    t_underrun();
    t_external();
    t_timers();
    t_disabled();
    t_wrap();
    t_global();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule